// File: doc/BRIEF.md
# Multi-Stream Stride Prefetcher

This block watches the line addresses of cache misses and turns regular miss patterns into prefetch requests. Each miss is sorted into a stream by its page. A stream remembers the last line it saw, the distance to the line before it, and a saturating confidence count. A miss that repeats the stored distance raises a request for the next line at that distance. Strides may be positive or negative and of any size that fits inside a page. Requests never leave the page of the miss that caused them.

The stream table has a fixed number of entries, normally 8 or 16. A miss to a page that no entry tracks takes the least recently used entry. Requests leave through a one-deep valid/ready register. When the consumer stalls, a newer request replaces the pending one, so requests never build up.

Top module: `stride_prefetcher`

## Requirements
- R1: A miss whose page matches no valid stream allocates an entry. The page is the line address bits above the low log2(PAGE_BYTES/LINE_BYTES) offset bits. Neither that miss nor the next different miss in the same page, which sets the stride, raises a request.
- R2: A miss is line last+stride in the page of a stream whose stride is set. Its confidence then reaches CONF_THRESH (default 1). In that case pf_valid_o is high after the next rising edge, with pf_line_o = miss line + stride. This holds for positive and negative strides.
- R3: Each miss updates only the stream of its own page. Interleaved misses to different pages keep separate strides and each stream raises its own requests.
- R4: A request whose target line lies in a different page from the triggering miss is suppressed. Targets at offset 0 or at the last offset of the page are still issued.
- R5: A miss in a tracked page at a nonzero distance other than the stored stride raises no request. It replaces the stored stride with the new distance and clears the confidence.
- R6: A miss to the same line as the stream's last line raises no request and leaves the stream unchanged.
- R7: Replacement is least recently used over NUM_STREAMS entries, where both allocations and hits count as uses. A stream that has been evicted starts again as in R1.
- R8: While pf_valid_o is high and pf_ready_i is low, pf_line_o holds. A newer request overwrites the pending one. pf_valid_o drops after the edge that completes the handshake, unless a new request loads on that edge.
- R9: After reset pf_valid_o is low and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| miss_valid_i | input | 1 | A miss is presented this cycle |
| miss_line_i | input | LINE_W | Line address of the miss |
| pf_ready_i | input | 1 | Consumer accepts the pending request |
| pf_valid_o | output | 1 | A prefetch request is pending |
| pf_line_o | output | LINE_W | Line address to prefetch |

## Verification
A miss is sampled on a rising edge, and its request is visible on pf_valid_o and pf_line_o right after that same edge. The bench therefore drives each miss for one cycle from a falling edge and checks the outputs at the following falling edge. With pf_ready_i high, a request lasts exactly one cycle, so every check starts from an empty output. The stall checks lower pf_ready_i first, and then sample the held value at falling edges over several idle and miss cycles. They also check that the request is gone one cycle after ready rises. Strides from -9 to +9 are swept, along with page-edge targets on both sides of a page.

// File: rtl/stpf_pkg.sv
package stpf_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_SET,
    ACT_MATCH,
    ACT_RETRAIN,
    ACT_REPEAT
  } stpf_act_e;
endpackage

// File: rtl/stpf_entry.sv
module stpf_entry
  import stpf_pkg::*;
#(
  parameter int LINE_W      = 26,
  parameter int OFF_W       = 6,
  parameter int CONF_W      = 2,
  parameter int CONF_THRESH = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic [LINE_W-1:0] miss_line_i,
  input  logic              alloc_i,
  output logic              hit_o,
  output logic              issue_o,
  output logic [LINE_W-1:0] tgt_line_o
);
  localparam int DeltaW = OFF_W + 1;

  logic                     valid_q, have_q;
  logic [LINE_W-1:0]        last_q;
  logic [DeltaW-1:0]        stride_q;
  logic [CONF_W-1:0]        conf_q, conf_nxt;
  logic [DeltaW-1:0]        delta;
  logic                     tgt_in_page;
  stpf_act_e                act;

  always_comb begin
    hit_o = valid_q && (miss_line_i[LINE_W-1:OFF_W] == last_q[LINE_W-1:OFF_W]);
    delta = {1'b0, miss_line_i[OFF_W-1:0]} - {1'b0, last_q[OFF_W-1:0]};
    if (!hit_o)                 act = ACT_NONE;
    else if (delta == '0)       act = ACT_REPEAT;
    else if (!have_q)           act = ACT_SET;
    else if (delta == stride_q) act = ACT_MATCH;
    else                        act = ACT_RETRAIN;
    conf_nxt    = (conf_q == '1) ? conf_q : conf_q + 1'b1;
    tgt_line_o  = miss_line_i + {{(LINE_W-DeltaW){stride_q[DeltaW-1]}}, stride_q};
    tgt_in_page = tgt_line_o[LINE_W-1:OFF_W] == miss_line_i[LINE_W-1:OFF_W];
    issue_o     = miss_valid_i && (act == ACT_MATCH) &&
                  (conf_nxt >= CONF_W'(CONF_THRESH)) && tgt_in_page;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      have_q   <= 1'b0;
      last_q   <= '0;
      stride_q <= '0;
      conf_q   <= '0;
    end else if (miss_valid_i) begin
      if (alloc_i) begin
        valid_q  <= 1'b1;
        have_q   <= 1'b0;
        last_q   <= miss_line_i;
        stride_q <= '0;
        conf_q   <= '0;
      end else begin
        unique case (act)
          ACT_SET, ACT_RETRAIN: begin
            have_q   <= 1'b1;
            stride_q <= delta;
            conf_q   <= '0;
            last_q   <= miss_line_i;
          end
          ACT_MATCH: begin
            conf_q <= conf_nxt;
            last_q <= miss_line_i;
          end
          default: ;
        endcase
      end
    end
  end

  AST_REPEAT_KEEPS_STREAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && !alloc_i && act == ACT_REPEAT) |=> ($stable(stride_q) && $stable(conf_q) && $stable(last_q))); // R6
  AST_RETRAIN_CLEARS_CONF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && !alloc_i && act == ACT_RETRAIN) |=> (conf_q == '0 && have_q)); // R5
  AST_NO_ALLOC_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && alloc_i) |-> !hit_o); // R1
endmodule

// File: rtl/stpf_lru.sv
module stpf_lru #(
  parameter int NUM_STREAMS = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   touch_valid_i,
  input  logic [NUM_STREAMS-1:0] touch_vec_i,
  output logic [NUM_STREAMS-1:0] victim_vec_o
);
  localparam int AgeW = $clog2(NUM_STREAMS);

  logic [AgeW-1:0] age_q [NUM_STREAMS];
  logic [AgeW-1:0] touched_age;

  always_comb begin
    touched_age = '0;
    for (int i = 0; i < NUM_STREAMS; i++) begin
      if (touch_vec_i[i]) touched_age = touched_age | age_q[i];
      victim_vec_o[i] = (age_q[i] == AgeW'(NUM_STREAMS - 1));
    end
  end

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              age_q[g] <= AgeW'(NUM_STREAMS - 1 - g);
      else if (touch_valid_i && touch_vec_i[g]) age_q[g] <= '0;
      else if (touch_valid_i && age_q[g] < touched_age) age_q[g] <= age_q[g] + 1'b1;
    end
  end

  AST_LRU_ONE_VICTIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(victim_vec_o)); // R7
  AST_LRU_TOUCH_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_valid_i |-> $onehot(touch_vec_i)); // R7
endmodule

// File: rtl/stpf_pf_reg.sv
module stpf_pf_reg #(
  parameter int LINE_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [LINE_W-1:0] line_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      line_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;  // newest request overwrites any pending one
      line_o  <= line_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_PF_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (valid_o && line_o == $past(line_i))); // R2
  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !load_i) |=> (valid_o && $stable(line_o))); // R8
  AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && !load_i) |=> !valid_o); // R8
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
  parameter int NUM_STREAMS = 8,
  parameter int LINE_W      = 26,
  parameter int PAGE_BYTES  = 4096,
  parameter int LINE_BYTES  = 64,
  parameter int CONF_W      = 2,
  parameter int CONF_THRESH = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic [LINE_W-1:0] miss_line_i,
  input  logic              pf_ready_i,
  output logic              pf_valid_o,
  output logic [LINE_W-1:0] pf_line_o
);
  localparam int OffW = $clog2(PAGE_BYTES / LINE_BYTES);

  logic [NUM_STREAMS-1:0] hit_vec, issue_vec, victim_vec, alloc_vec, touch_vec;
  logic [LINE_W-1:0]      tgt_arr [NUM_STREAMS];
  logic                   any_hit, alloc, pf_issue;
  logic [LINE_W-1:0]      pf_tgt;

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_stream
    stpf_entry #(
      .LINE_W      (LINE_W),
      .OFF_W       (OffW),
      .CONF_W      (CONF_W),
      .CONF_THRESH (CONF_THRESH)
    ) i_entry (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .miss_valid_i (miss_valid_i),
      .miss_line_i  (miss_line_i),
      .alloc_i      (alloc_vec[g]),
      .hit_o        (hit_vec[g]),
      .issue_o      (issue_vec[g]),
      .tgt_line_o   (tgt_arr[g])
    );
  end

  always_comb begin
    any_hit   = |hit_vec;
    alloc     = miss_valid_i && !any_hit;
    alloc_vec = victim_vec & {NUM_STREAMS{alloc}};
    touch_vec = any_hit ? hit_vec : victim_vec;
    pf_issue  = |issue_vec;
    pf_tgt    = '0;
    for (int i = 0; i < NUM_STREAMS; i++)
      if (issue_vec[i]) pf_tgt = pf_tgt | tgt_arr[i];
  end

  stpf_lru #(.NUM_STREAMS(NUM_STREAMS)) i_lru (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .touch_valid_i (miss_valid_i),
    .touch_vec_i   (touch_vec),
    .victim_vec_o  (victim_vec)
  );

  stpf_pf_reg #(.LINE_W(LINE_W)) i_pf_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (pf_issue),
    .line_i  (pf_tgt),
    .ready_i (pf_ready_i),
    .valid_o (pf_valid_o),
    .line_o  (pf_line_o)
  );

  AST_PAGE_HIT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec)); // R3
  AST_NO_PF_ON_ALLOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc |-> !pf_issue); // R1
  AST_ONE_ISSUER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(issue_vec)); // R3
endmodule

// File: tb/test_stride_prefetcher.sv
`timescale 1ns/1ps
module test_stride_prefetcher;
  localparam int LW = 20;
  localparam int LPP = 64;  // lines per page with 4 KiB pages and 64 B lines

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          miss_valid = 1'b0;
  logic [LW-1:0] miss_line = '0;
  logic          pf_ready = 1'b1;
  logic          pf_valid;
  logic [LW-1:0] pf_line;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  stride_prefetcher #(
    .NUM_STREAMS (4),
    .LINE_W      (LW),
    .PAGE_BYTES  (4096),
    .LINE_BYTES  (64),
    .CONF_W      (2),
    .CONF_THRESH (1)
  ) i_stride_prefetcher (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .miss_valid_i (miss_valid),
    .miss_line_i  (miss_line),
    .pf_ready_i   (pf_ready),
    .pf_valid_o   (pf_valid),
    .pf_line_o    (pf_line)
  );

  task automatic do_miss(input int page, input int off);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_line  = LW'(page * LPP + off);
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic chk_pf(input string req, input bit exp_v, input int exp_line);
    n_chk++;
    if (pf_valid !== exp_v || (exp_v && int'(pf_line) != exp_line)) begin
      n_fail++;
      $display("FAIL %s: valid=%0b line=%0d expected valid=%0b line=%0d",
               req, pf_valid, pf_line, exp_v, exp_line);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: valid=%0b line=%0d expected valid=0 line=0", pf_valid, pf_line);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_pf("R9 reset", 1'b0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_pf("R9 after release", 1'b0, 0);

    // stride sweep, one fresh page per stride
    for (int s = -9; s <= 9; s++) begin
      int pg, o;
      if (s == 0) continue;
      pg = 120 + s;
      o  = (s > 0) ? 2 : 61;
      do_miss(pg, o);         chk_pf("R1 alloc miss", 1'b0, 0);
      do_miss(pg, o + s);     chk_pf("R1 stride setting miss", 1'b0, 0);
      do_miss(pg, o + 2 * s); chk_pf("R2 first match", 1'b1, pg * LPP + o + 3 * s);
      do_miss(pg, o + 3 * s); chk_pf("R2 second match", 1'b1, pg * LPP + o + 4 * s);
      @(negedge clk);         chk_pf("R2 one-cycle request", 1'b0, 0);
    end

    // page edges
    do_miss(300, 3); do_miss(300, 23); do_miss(300, 43);
    chk_pf("R4 last offset in page", 1'b1, 300 * LPP + 63);
    do_miss(301, 4); do_miss(301, 24); do_miss(301, 44);
    chk_pf("R4 crossing upward", 1'b0, 0);
    do_miss(302, 60); do_miss(302, 40); do_miss(302, 20);
    chk_pf("R4 offset zero", 1'b1, 302 * LPP);
    do_miss(303, 59); do_miss(303, 39); do_miss(303, 19);
    chk_pf("R4 crossing downward", 1'b0, 0);

    // stride change
    do_miss(310, 0); do_miss(310, 2); do_miss(310, 4);
    chk_pf("R5 before change", 1'b1, 310 * LPP + 6);
    do_miss(310, 7);  chk_pf("R5 mismatch", 1'b0, 0);
    do_miss(310, 10); chk_pf("R5 new stride", 1'b1, 310 * LPP + 13);

    // repeated line
    do_miss(320, 0); do_miss(320, 4);
    do_miss(320, 4); chk_pf("R6 repeat", 1'b0, 0);
    do_miss(320, 8); chk_pf("R6 stream kept", 1'b1, 320 * LPP + 12);

    // interleaved streams
    do_miss(330, 0); do_miss(331, 0);
    do_miss(330, 1); do_miss(331, 5);
    do_miss(330, 2);  chk_pf("R3 stream A", 1'b1, 330 * LPP + 3);
    do_miss(331, 10); chk_pf("R3 stream B", 1'b1, 331 * LPP + 15);
    do_miss(330, 3);  chk_pf("R3 stream A again", 1'b1, 330 * LPP + 4);

    // replacement
    do_miss(340, 0); do_miss(340, 3);
    do_miss(341, 0); do_miss(342, 0); do_miss(343, 0);
    do_miss(340, 6); chk_pf("R7 survives three allocations", 1'b1, 340 * LPP + 9);
    do_miss(344, 0); do_miss(345, 0); do_miss(346, 0); do_miss(347, 0);
    do_miss(340, 9);  chk_pf("R7 evicted restarts", 1'b0, 0);
    do_miss(340, 12); chk_pf("R7 restart stride", 1'b0, 0);
    do_miss(340, 15); chk_pf("R7 retrained", 1'b1, 340 * LPP + 18);

    // stall and overwrite
    @(negedge clk);
    pf_ready = 1'b0;
    do_miss(350, 0); do_miss(350, 1); do_miss(350, 2);
    chk_pf("R8 stalled request", 1'b1, 350 * LPP + 3);
    repeat (3) @(negedge clk);
    chk_pf("R8 held while idle", 1'b1, 350 * LPP + 3);
    do_miss(351, 0); do_miss(351, 2);
    chk_pf("R8 held across misses", 1'b1, 350 * LPP + 3);
    do_miss(351, 4);
    chk_pf("R8 overwrite", 1'b1, 351 * LPP + 6);
    pf_ready = 1'b1;
    @(negedge clk);
    chk_pf("R8 drop after accept", 1'b0, 0);

    finish_run();
  end
endmodule